// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

A clocked single-port memory with a built-in 2-bit burst address counter. Words are built from `LANES` byte lanes of `LANE_W` bits each. Every control input is sampled on the rising clock edge. The exceptions are the output enable `oe_n` and the sleep input `sleep`, which gate the read outputs combinationally.

An access sequence opens with either of two active-low start strobes: `strb_proc_n`, which always reads, or `strb_ctrl_n`, which reads or writes according to the write controls. The opening only happens if all three chip enables select the part. After that, each cycle with `adv_n` low performs one more access at the next address in the burst. The next address comes from a 2-bit counter that runs in linear or interleaved order. Since a new start may be issued on any cycle, the burst counter is optional.

Read data leaves either straight from the array read register (flow-through) or through one extra output register (pipelined). An output-valid flag accompanies the data.

The controller is a state machine with five states:

- **IDLE** (deselected)
- **FIRST_RD**
- **FIRST_WR**
- **BURST_RD**
- **BURST_WR**

Its transitions are:

- **select-read**: a start with chip selected and a read decision goes to FIRST_RD.
- **select-write**: a start with chip selected and a write decision goes to FIRST_WR.
- **deselect**: a start with chip not selected goes to IDLE.
- **advance-read / advance-write**: `adv_n` low in any state other than IDLE, with no start, goes to BURST_RD or BURST_WR according to the write controls.
- **suspend**: `adv_n` high with no start holds the state.
- **sleep-hold**: `sleep` high holds every state and counter.

Top module: `burst_sram`

## Requirements
- R1: A start cycle accesses memory only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. Any other combination is a deselect: no access takes place, and later `adv_n` pulses do nothing until the next selected start.
- R2: A start from `strb_proc_n` low is always a read, whatever the write controls are, and it wins when both strobes are low. A start from `strb_ctrl_n` alone is a write if `all_we_n`=0, or if `byte_we_n`=0 with at least one `lane_we_n` bit at 0. Otherwise it is a read.
- R3: In any state other than IDLE, a cycle with no start and `adv_n`=0 steps the 2-bit counter and accesses the next burst address. With `adv_n`=1, the access and the counter are both suspended.
- R4: With `order_lin_n`=0, the burst address has low two bits equal to (start bits [1:0] + count) mod 4. The upper bits are unchanged.
- R5: With `order_lin_n`=1, the low two bits are (start bits [1:0]) XOR count.
- R6: The counter wraps after four accesses, so the fifth access of a burst returns to the starting address.
- R7: A write enabled by `byte_we_n`=0 (with `all_we_n`=1) updates only lanes i whose `lane_we_n[i]`=0. Lane i is `wdata` bits [8i+7:8i].
- R8: A write with `all_we_n`=0 updates every lane, whatever `byte_we_n` and `lane_we_n` are.
- R9: A read sampled at edge k drives `rvalid`=1 and the word on `rdata`:
  - with `flow_n`=0, from just after edge k until edge k+1;
  - with `flow_n`=1, one cycle later, from just after edge k+1 until edge k+2.
- R10: `oe_n`=1 forces `rvalid`=0 and `rdata`=0 at once. A read performed with `oe_n`=1 still advances the burst.
- R11: `sleep`=1 forces `rvalid`=0 and `rdata`=0 at once. Clock edges seen while `sleep`=1 perform no access and leave memory contents and the burst position unchanged.
- R12: After synchronous reset (`rst_n`=0), the controller is in IDLE, and `rvalid`=0 and `rdata`=0.
- R13: A burst cycle with `adv_n`=0 chooses read or write from the write controls as in R2. This allows a change from reading to writing without a deselect cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | AW | Word address sampled on a start |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| strb_proc_n | input | 1 | Read-only start strobe, active low |
| strb_ctrl_n | input | 1 | Read/write start strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| byte_we_n | input | 1 | Lane-masked write enable, active low |
| all_we_n | input | 1 | All-lane write enable, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous low-power hold, active high |
| order_lin_n | input | 1 | Burst order: 0 linear, 1 interleaved |
| flow_n | input | 1 | Read path: 0 flow-through, 1 pipelined |
| wdata | input | LANES*LANE_W | Write data, sampled with each write access |
| rdata | output | LANES*LANE_W | Read data, 0 when not valid |
| rvalid | output | 1 | Read data valid |

## Verification
The bench aims at the following corner cases:

- **Burst wrap.** A burst starting at low bits 2 runs past four accesses in both orders. A counter that carries into the upper address, or that applies the wrong order, returns the wrong words on the fifth and sixth reads.
- **Read latency.** A bench cycle shifted by one exposes a latency off by one in either read mode.
- **Strobe and write-control decode.** A processor start with write controls asserted, and a mid-burst switch from reading to writing, catch a decoder that lets the processor strobe write or that locks the read/write decision for the whole burst.
- **Dummy read, sleep and deselect.** A dummy read with `oe_n` high shows whether it advances the burst. A write attempted during sleep must leave memory intact. Partial chip-enable patterns must not access memory.

Any failure in these cases shows up as a mismatch against the bench model on some cycle.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FIRST_RD,
        ST_FIRST_WR,
        ST_BURST_RD,
        ST_BURST_WR
    } bst_e;

    // Low two address bits for a burst position: linear adds, interleaved XORs.
    function automatic logic [1:0] burst_lsb(input logic [1:0] base,
                                             input logic [1:0] cnt,
                                             input logic       linear);
        return linear ? (base + cnt) : (base ^ cnt);
    endfunction

endpackage

// File: rtl/bsram_ctrl.sv
module bsram_ctrl
    import bsram_pkg::*;
#(
    parameter int AW    = 6,
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep,
    input  logic [AW-1:0]    addr,
    input  logic             ce1_n,
    input  logic             ce2,
    input  logic             ce3_n,
    input  logic             strb_proc_n,
    input  logic             strb_ctrl_n,
    input  logic             adv_n,
    input  logic [LANES-1:0] lane_we_n,
    input  logic             byte_we_n,
    input  logic             all_we_n,
    input  logic             order_lin_n,
    output logic [AW-1:0]    acc_addr,
    output logic             acc_rd,
    output logic             acc_wr,
    output logic [LANES-1:0] acc_mask
);

    bst_e          state_q, state_d;
    logic [AW-1:0] base_q, base_d;
    logic [1:0]    cnt_q, cnt_d;
    logic          start, chip_sel, wr_req, fire;

    assign start    = !strb_proc_n || !strb_ctrl_n;
    assign chip_sel = !ce1_n && ce2 && !ce3_n;
    assign wr_req   = !all_we_n || (!byte_we_n && !(&lane_we_n));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            base_q  <= base_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state, burst base and counter
    always_comb begin
        state_d = state_q;
        base_d  = base_q;
        cnt_d   = cnt_q;
        fire    = 1'b0;
        if (sleep) begin
            fire = 1'b0;
        end else if (start) begin
            if (chip_sel) begin
                base_d  = addr;
                cnt_d   = 2'd0;
                fire    = 1'b1;
                state_d = (!strb_proc_n || !wr_req) ? ST_FIRST_RD : ST_FIRST_WR;
            end else begin
                state_d = ST_IDLE;
            end
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                default: begin
                    if (!adv_n) begin
                        cnt_d   = cnt_q + 2'd1;
                        fire    = 1'b1;
                        state_d = wr_req ? ST_BURST_WR : ST_BURST_RD;
                    end
                end
            endcase
        end
    end

    // Access outputs
    always_comb begin
        acc_rd   = 1'b0;
        acc_wr   = 1'b0;
        acc_addr = {base_d[AW-1:2], burst_lsb(base_d[1:0], cnt_d, !order_lin_n)};
        acc_mask = !all_we_n ? {LANES{1'b1}} : (!byte_we_n ? ~lane_we_n : '0);
        unique case (state_d)
            ST_FIRST_WR, ST_BURST_WR: acc_wr = fire;
            ST_FIRST_RD, ST_BURST_RD: acc_rd = fire;
            default: begin
                acc_rd = 1'b0;
                acc_wr = 1'b0;
            end
        endcase
    end

    assert_deselect_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && start && !chip_sel) |=> (state_q == ST_IDLE));

    assert_proc_never_writes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !strb_proc_n) |-> !acc_wr);

    assert_suspend_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !start && adv_n) |=> ($stable(cnt_q) && $stable(base_q)));

    assert_sleep_no_access_R11: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (!acc_rd && !acc_wr));

endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
    parameter int AW     = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           acc_addr,
    input  logic                    acc_rd,
    input  logic                    acc_wr,
    input  logic [LANES-1:0]        acc_mask,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] s1_data,
    output logic                    s1_valid
);

    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem_q [DEPTH];
        logic [LANE_W-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (acc_wr && acc_mask[g])
                mem_q[acc_addr] <= wdata[g*LANE_W +: LANE_W];
            if (acc_rd)
                rd_q <= mem_q[acc_addr];
        end

        assign s1_data[g*LANE_W +: LANE_W] = rd_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s1_valid <= 1'b0;
        else        s1_valid <= acc_rd;
    end

    assert_rd_wr_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_rd && acc_wr));

endmodule

// File: rtl/bsram_out.sv
module bsram_out #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flow_n,
    input  logic          oe_n,
    input  logic          sleep,
    input  logic [DW-1:0] s1_data,
    input  logic          s1_valid,
    output logic [DW-1:0] rdata,
    output logic          rvalid
);

    logic [DW-1:0] s2_data;
    logic          s2_valid;
    logic          pick_v;
    logic [DW-1:0] pick_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_valid <= 1'b0;
            s2_data  <= '0;
        end else begin
            s2_valid <= sleep ? 1'b0 : s1_valid;
            s2_data  <= s1_data;
        end
    end

    assign pick_v = flow_n ? s2_valid : s1_valid;
    assign pick_d = flow_n ? s2_data  : s1_data;
    assign rvalid = pick_v && !oe_n && !sleep;
    assign rdata  = rvalid ? pick_d : '0;

endmodule

// File: rtl/burst_sram.sv
module burst_sram #(
    parameter int AW     = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           addr,
    input  logic                    ce1_n,
    input  logic                    ce2,
    input  logic                    ce3_n,
    input  logic                    strb_proc_n,
    input  logic                    strb_ctrl_n,
    input  logic                    adv_n,
    input  logic [LANES-1:0]        lane_we_n,
    input  logic                    byte_we_n,
    input  logic                    all_we_n,
    input  logic                    oe_n,
    input  logic                    sleep,
    input  logic                    order_lin_n,
    input  logic                    flow_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rvalid
);

    localparam int DW = LANES * LANE_W;

    logic [AW-1:0]    acc_addr;
    logic             acc_rd, acc_wr;
    logic [LANES-1:0] acc_mask;
    logic [DW-1:0]    s1_data;
    logic             s1_valid;

    bsram_ctrl #(.AW(AW), .LANES(LANES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .addr(addr),
        .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
        .strb_proc_n(strb_proc_n), .strb_ctrl_n(strb_ctrl_n), .adv_n(adv_n),
        .lane_we_n(lane_we_n), .byte_we_n(byte_we_n), .all_we_n(all_we_n),
        .order_lin_n(order_lin_n),
        .acc_addr(acc_addr), .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_mask(acc_mask)
    );

    bsram_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_rd(acc_rd),
        .acc_wr(acc_wr), .acc_mask(acc_mask), .wdata(wdata),
        .s1_data(s1_data), .s1_valid(s1_valid)
    );

    bsram_out #(.DW(DW)) u_out (
        .clk(clk), .rst_n(rst_n), .flow_n(flow_n), .oe_n(oe_n), .sleep(sleep),
        .s1_data(s1_data), .s1_valid(s1_valid), .rdata(rdata), .rvalid(rvalid)
    );

    assert_flow_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!flow_n && rvalid) |-> $past(acc_rd));

    assert_pipe_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_n && $past(flow_n) && rvalid) |-> $past(acc_rd, 2));

endmodule

// File: tb/burst_sram_bench.sv
`timescale 1ns/1ps
module burst_sram_bench;

    localparam int AW = 6;
    localparam int LANES = 4;
    localparam int LW = 8;
    localparam int DW = LANES * LW;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic ce1_n = 1'b0, ce2 = 1'b1, ce3_n = 1'b0;
    logic strb_proc_n = 1'b1, strb_ctrl_n = 1'b1, adv_n = 1'b1;
    logic [LANES-1:0] lane_we_n = '1;
    logic byte_we_n = 1'b1, all_we_n = 1'b1;
    logic oe_n = 1'b0, sleep = 1'b0, order_lin_n = 1'b1, flow_n = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic rvalid;

    always #2 clk = ~clk;

    burst_sram #(.AW(AW), .LANES(LANES), .LANE_W(LW)) u_burst_sram (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
        .strb_proc_n(strb_proc_n), .strb_ctrl_n(strb_ctrl_n), .adv_n(adv_n),
        .lane_we_n(lane_we_n), .byte_we_n(byte_we_n), .all_we_n(all_we_n),
        .oe_n(oe_n), .sleep(sleep), .order_lin_n(order_lin_n), .flow_n(flow_n),
        .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
    );

    // Behavioural reference model
    logic [DW-1:0] mdl_mem [DEPTH];
    bit            m_active;
    int            m_base, m_cnt;
    bit            m_s1v, m_s2v;
    logic [DW-1:0] m_s1d, m_s2d;

    int total = 0, bad = 0;
    bit done = 0;
    string cur_req = "R12";

    always @(posedge clk) begin
        bit go, is_wr, wrq, sel;
        int a, lsb;
        go = 0; is_wr = 0;
        if (!rst_n) begin
            m_active = 0; m_s1v = 0; m_s2v = 0;
        end else if (sleep) begin
            m_s2v = 0; m_s2d = m_s1d; m_s1v = 0;
        end else begin
            m_s2v = m_s1v; m_s2d = m_s1d;
            sel = (ce1_n == 0) && (ce2 == 1) && (ce3_n == 0);
            wrq = (all_we_n == 0) || ((byte_we_n == 0) && (lane_we_n != '1));
            if (!strb_proc_n || !strb_ctrl_n) begin
                if (sel) begin
                    m_active = 1; m_base = int'(addr); m_cnt = 0; go = 1;
                    is_wr = strb_proc_n && wrq;
                end else m_active = 0;
            end else if (m_active && !adv_n) begin
                m_cnt = (m_cnt + 1) % 4; go = 1; is_wr = wrq;
            end
            m_s1v = 0;
            if (go) begin
                if (order_lin_n == 0) lsb = ((m_base % 4) + m_cnt) % 4;
                else                  lsb = (m_base % 4) ^ m_cnt;
                a = (m_base / 4) * 4 + lsb;
                if (is_wr) begin
                    for (int i = 0; i < LANES; i++)
                        if (all_we_n == 0 || lane_we_n[i] == 0)
                            mdl_mem[a][i*LW +: LW] = wdata[i*LW +: LW];
                end else begin
                    m_s1v = 1; m_s1d = mdl_mem[a];
                end
            end
        end
    end

    task automatic compare();
        bit ev;
        logic [DW-1:0] ed;
        ev = (flow_n ? m_s2v : m_s1v) && !oe_n && !sleep;
        ed = ev ? (flow_n ? m_s2d : m_s1d) : '0;
        total++;
        if (rvalid !== ev || rdata !== ed) begin
            bad++;
            $display("FAIL %s t=%0t rvalid=%b rdata=%h expected rvalid=%b rdata=%h",
                     cur_req, $time, rvalid, rdata, ev, ed);
        end
    endtask

    task automatic tick();
        #1 compare();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic quiet();
        strb_proc_n = 1; strb_ctrl_n = 1; adv_n = 1;
        all_we_n = 1; byte_we_n = 1; lane_we_n = '1;
        ce1_n = 0; ce2 = 1; ce3_n = 0;
    endtask

    task automatic proc_start(input int a);
        quiet(); addr = AW'(a); strb_proc_n = 0; tick();
    endtask

    task automatic advance(input int n);
        for (int i = 0; i < n; i++) begin
            quiet(); adv_n = 0; tick();
        end
    endtask

    task automatic drain();
        quiet(); tick(); tick(); tick();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        @(negedge clk);
        // R12: reset state
        cur_req = "R12";
        for (int i = 0; i < 3; i++) tick();
        total++;
        if (rvalid !== 1'b0 || rdata !== '0) begin
            bad++;
            $display("FAIL R12 rvalid=%b rdata=%h expected 0/0", rvalid, rdata);
        end
        rst_n = 1; tick();

        // R8: fill every word with all-lane writes via single starts
        cur_req = "R8";
        for (int a = 0; a < DEPTH; a++) begin
            quiet(); addr = AW'(a); strb_ctrl_n = 0; all_we_n = 0;
            byte_we_n = 1; lane_we_n = 4'b0101; wdata = $urandom; tick();
        end
        drain();

        // R4/R6: linear burst from low bits 2, wrapping
        cur_req = "R4 R6 linear"; order_lin_n = 0; flow_n = 0;
        proc_start(6); advance(5); drain();
        // R5/R6: interleaved burst
        cur_req = "R5 R6 interleaved"; order_lin_n = 1;
        proc_start(6); advance(5); drain();
        proc_start(13); advance(3); drain();
        // R9: pipelined read path
        cur_req = "R9 pipelined"; flow_n = 1;
        proc_start(20); advance(3); drain();
        proc_start(33); proc_start(40); proc_start(41); drain();
        flow_n = 0;
        cur_req = "R9 flow-through";
        proc_start(50); proc_start(51); advance(2); drain();

        // R7: lane-masked write then read back
        cur_req = "R7 byte write";
        quiet(); addr = 9; strb_ctrl_n = 0; byte_we_n = 0; lane_we_n = 4'b1010;
        wdata = 32'hA1B2C3D4; tick();
        quiet(); addr = 10; strb_ctrl_n = 0; byte_we_n = 1; lane_we_n = 4'b0000;
        wdata = 32'h11111111; tick();
        proc_start(9); proc_start(10); drain();

        // R2: processor start with write controls asserted stays a read
        cur_req = "R2 strobes";
        quiet(); addr = 12; strb_proc_n = 0; all_we_n = 0; wdata = 32'hDEADBEEF; tick();
        quiet(); addr = 12; strb_proc_n = 0; strb_ctrl_n = 0; all_we_n = 0; tick();
        proc_start(12); drain();

        // R3: suspend mid-burst, and advance while idle
        cur_req = "R3 suspend";
        proc_start(24); advance(1); quiet(); tick(); tick(); advance(2); drain();
        quiet(); ce1_n = 1; strb_proc_n = 0; tick();
        advance(3); drain();

        // R13: burst switches from reading to writing
        cur_req = "R13 read to write";
        proc_start(28); advance(1);
        quiet(); adv_n = 0; all_we_n = 0; wdata = 32'h0BADF00D; tick();
        quiet(); adv_n = 0; byte_we_n = 0; lane_we_n = 4'b1110; wdata = 32'h55667788; tick();
        advance(2); drain();

        // R10: dummy read with output disabled still steps the burst
        cur_req = "R10 output enable";
        quiet(); addr = 36; strb_proc_n = 0; oe_n = 1; tick();
        quiet(); adv_n = 0; tick();
        oe_n = 0; advance(3); drain();

        // R1: deselect patterns
        cur_req = "R1 deselect";
        quiet(); addr = 44; strb_proc_n = 0; ce2 = 0; tick();
        advance(2);
        quiet(); addr = 44; strb_ctrl_n = 0; all_we_n = 0; ce3_n = 1; wdata = 32'hFFFF0000; tick();
        quiet(); addr = 44; strb_ctrl_n = 0; all_we_n = 0; ce1_n = 1; tick();
        proc_start(44); drain();

        // R11: sleep in the middle of a burst, with attempted write
        cur_req = "R11 sleep";
        proc_start(52); advance(1);
        quiet(); sleep = 1; addr = 52; strb_ctrl_n = 0; all_we_n = 0; wdata = 32'h12345678; tick();
        quiet(); sleep = 1; adv_n = 0; tick();
        sleep = 0; advance(3); proc_start(52); drain();
        flow_n = 1; proc_start(53); quiet(); sleep = 1; tick(); sleep = 0; tick(); drain();

        // Mixed traffic
        cur_req = "R1 R2 R3 R13 mixed";
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            quiet();
            addr = AW'($urandom);
            wdata = $urandom;
            lane_we_n = LANES'($urandom);
            byte_we_n = $urandom_range(0, 1);
            all_we_n = ($urandom_range(0, 3) != 0);
            if (r < 15) strb_proc_n = 0;
            else if (r < 30) strb_ctrl_n = 0;
            else if (r < 85) adv_n = 0;
            if ($urandom_range(0, 15) == 0) ce2 = 0;
            oe_n = ($urandom_range(0, 9) == 0);
            sleep = ($urandom_range(0, 19) == 0);
            if ((i % 500) == 0) begin
                order_lin_n = $urandom_range(0, 1);
                flow_n = $urandom_range(0, 1);
            end
            tick();
        end
        oe_n = 0; sleep = 0; drain();
        finish_run();
    end

endmodule